// File: doc/BRIEF.md
# PLL Power Sequencer

This block brings one PLL up and down in a fixed, safe order. It owns the PLL control word: divider factors, bandwidth setting, power, reset, bypass and enable. A one-cycle enable request starts the power-up. The block loads the factors, pulses the PLL reset low, then high, then low, and polls the lock indication. While lock is not yet complete it pulses a slip-clear strobe. Once lock holds, it releases bypass and sets enable in the same cycle. A disable request sets bypass before it removes power, so that downstream clocks keep running from the raw input.

The parameter `IDX` selects which of three PLL instances the sequencer serves. Instance 0 feeds the CPU clock. For that instance the sequencer moves the CPU clock selector to the oscillator for the length of a power-up and returns it to the PLL afterwards. Instance 0 has a two-bit lock field. The other instances have one lock bit. Only instance 2 carries an input-source select field in its control word.

A registered ratio output gives the expected output/input frequency ratio as a numerator and a denominator.

Top module: `pllseq_top`

## Requirements
- R1: After the synchronous reset, the control word is 0x0800000 (only bypass set). `busy`, `done`, `err` and `slip_clr` are 0, `cpu_sel_pll` is 1, and the ratio is 1/1.
- R2: Control word layout:
  - R factor in bits 3:0, F in 9:4, OD in 13:10, bandwidth in 19:14.
  - Reset in bit 20, power in bit 21, internal feedback in bit 22 (held 0), bypass in bit 23, test in bit 24 (held 0), enable in bit 25, source select in 27:26.
  - A completed power-up of instance 0 leaves R=0, F=59, OD=1 and bandwidth=59 (instance 1: OD=3; instance 2: F=bandwidth=22).
- R3: Power-up order: factors and power in one cycle, then reset low, then reset high. Reset stays high for HOLD_CYC+1 cycles and then goes low. After that the lock is polled. Bypass clears and enable sets in the same cycle, and only after lock.
- R4: On instance 0, `cpu_sel_pll` drops to 0 before the factors load. It stays 0 until after enable has risen, and returns to 1 as the sequence completes.
- R5: Lock counts only when every bit of the lock field is 1 (for instance 0, `lock_in`=2'b11; 2'b01 is not lock). On each poll cycle without lock, `slip_clr` pulses high for one cycle.
- R6: If TIMEOUT_CYC polls pass without lock, the sequence ends:
  - `err` rises, `done` pulses, enable stays 0, and bypass and power stay set.
  - `err` clears when the next request is accepted.
- R7: If a PLL is already enabled (reset 0, power 1, enable 1), an enable request pulses `done` on the next cycle, does not raise `busy`, and leaves the word unchanged.
- R8: A disable request sets bypass one cycle before it clears power and enable in the same cycle, then pulses `done`.
- R9: `busy` is high from the cycle after acceptance until the sequence ends. Requests that arrive while `busy` is high are ignored.
- R10: If enable and disable requests arrive in the same idle cycle, the enable request wins.
- R11: The ratio output, registered one cycle behind the word, is:
  - 1/1 when bypass is set;
  - 0/1 when power is clear;
  - (F+1)/((R+1)·(OD+1)) otherwise.
- R12: Bits 27:26 follow `src_sel` (registered) only on instance 2. On other instances they stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Power-up request (sampled when idle) |
| dis_req | input | 1 | Power-down request (sampled when idle) |
| lock_in | input | LOCK_W | Lock field from the PLL; LOCK_W is 2 on instance 0, else 1 |
| src_sel | input | 2 | Reference select for instance 2 |
| ctl_word | output | 28 | PLL control word |
| slip_clr | output | 1 | One-cycle slip-clear strobe while polling |
| cpu_sel_pll | output | 1 | 1: CPU clock from PLL, 0: from oscillator |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Lock timeout flag |
| ratio_num | output | 7 | Expected ratio numerator |
| ratio_den | output | 10 | Expected ratio denominator |

## Verification
Two pairs of functions can meet in one cycle:
- An enable and a disable request can both arrive at an idle sequencer. The bench raises both strobes on the same edge and judges that power-up runs and enable ends high.
- A request can arrive while a sequence is running. The bench pulses both request kinds in the middle of a power-up. The cycle-by-cycle model flags any change to the word, the busy flag or the done pulse.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  localparam int CW      = 28;
  localparam int B_RST   = 20;
  localparam int B_PWR   = 21;
  localparam int B_IFB   = 22;
  localparam int B_BYP   = 23;
  localparam int B_TST   = 24;
  localparam int B_EN    = 25;
  localparam int SEL_LO  = 26;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FALLBK, ST_LOAD, ST_RLO, ST_RHI, ST_HOLD,
    ST_RREL, ST_POLL, ST_RUN, ST_RESTORE, ST_BYP, ST_OFF
  } seq_st_t;

  function automatic logic [3:0] dflt_r(input int idx);
    return 4'd0 + 4'(idx - idx);
  endfunction
  function automatic logic [5:0] dflt_f(input int idx);
    return (idx == 2) ? 6'd22 : 6'd59;
  endfunction
  function automatic logic [3:0] dflt_od(input int idx);
    return (idx == 1) ? 4'd3 : 4'd1;
  endfunction
  function automatic logic [5:0] dflt_bw(input int idx);
    return dflt_f(idx);
  endfunction
endpackage

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
#(
  parameter int IDX         = 0,
  parameter int HOLD_CYC    = 4,
  parameter int TIMEOUT_CYC = 1000,
  parameter int LOCK_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic [LOCK_W-1:0] lock_in,
  output logic [3:0]        fac_r,
  output logic [5:0]        fac_f,
  output logic [3:0]        fac_od,
  output logic [5:0]        fac_bw,
  output logic              rst_b,
  output logic              pwr_b,
  output logic              byp_b,
  output logic              en_b,
  output logic              cpu_sel,
  output logic              slip,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int MAXC = (HOLD_CYC > TIMEOUT_CYC) ? HOLD_CYC : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LAST   = CNT_W'(TIMEOUT_CYC - 1);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic             lock_full;
  logic             is_on;

  assign lock_full = &lock_in;
  assign is_on     = !rst_b && pwr_b && en_b;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      fac_r   <= '0;
      fac_f   <= '0;
      fac_od  <= '0;
      fac_bw  <= '0;
      rst_b   <= 1'b0;
      pwr_b   <= 1'b0;
      byp_b   <= 1'b1;
      en_b    <= 1'b0;
      cpu_sel <= 1'b1;
      slip    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      slip <= 1'b0;
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (en_req) begin
            err <= 1'b0;
            if (is_on) done <= 1'b1;
            else       st   <= (IDX == 0) ? ST_FALLBK : ST_LOAD;
          end else if (dis_req) begin
            err <= 1'b0;
            st  <= ST_BYP;
          end
        end
        ST_FALLBK: begin
          cpu_sel <= 1'b0;
          st      <= ST_LOAD;
        end
        ST_LOAD: begin
          fac_r  <= dflt_r(IDX);
          fac_f  <= dflt_f(IDX);
          fac_od <= dflt_od(IDX);
          fac_bw <= dflt_bw(IDX);
          pwr_b  <= 1'b1;
          st     <= ST_RLO;
        end
        ST_RLO: begin
          rst_b <= 1'b0;
          st    <= ST_RHI;
        end
        ST_RHI: begin
          rst_b <= 1'b1;
          cnt   <= '0;
          st    <= ST_HOLD;
        end
        ST_HOLD: begin
          if (cnt == HOLD_LAST) st <= ST_RREL;
          else                  cnt <= cnt + 1'b1;
        end
        ST_RREL: begin
          rst_b <= 1'b0;
          cnt   <= '0;
          st    <= ST_POLL;
        end
        ST_POLL: begin
          if (lock_full) begin
            st <= ST_RUN;
          end else if (cnt == TO_LAST) begin
            err  <= 1'b1;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            slip <= 1'b1;
            cnt  <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          byp_b <= 1'b0;
          en_b  <= 1'b1;
          if (IDX == 0) begin
            st <= ST_RESTORE;
          end else begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        ST_RESTORE: begin
          cpu_sel <= 1'b1;
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        ST_BYP: begin
          byp_b <= 1'b1;
          st    <= ST_OFF;
        end
        ST_OFF: begin
          pwr_b <= 1'b0;
          en_b  <= 1'b0;
          done  <= 1'b1;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pllseq_word.sv
module pllseq_word
  import pllseq_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    src_sel,
  input  logic [3:0]    fac_r,
  input  logic [5:0]    fac_f,
  input  logic [3:0]    fac_od,
  input  logic [5:0]    fac_bw,
  input  logic          rst_b,
  input  logic          pwr_b,
  input  logic          byp_b,
  input  logic          en_b,
  output logic [CW-1:0] ctl_word
);
  localparam bit HAS_SEL = (IDX == 2);

  logic [1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 2'b00;
    else     sel_q <= src_sel;
  end

  always_comb begin
    ctl_word         = '0;
    ctl_word[3:0]    = fac_r;
    ctl_word[9:4]    = fac_f;
    ctl_word[13:10]  = fac_od;
    ctl_word[19:14]  = fac_bw;
    ctl_word[B_RST]  = rst_b;
    ctl_word[B_PWR]  = pwr_b;
    ctl_word[B_IFB]  = 1'b0;
    ctl_word[B_BYP]  = byp_b;
    ctl_word[B_TST]  = 1'b0;
    ctl_word[B_EN]   = en_b;
    ctl_word[SEL_LO+1:SEL_LO] = HAS_SEL ? sel_q : 2'b00;
  end
endmodule

// File: rtl/pllseq_ratio.sv
module pllseq_ratio
  import pllseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ctl_word,
  output logic [6:0]    ratio_num,
  output logic [9:0]    ratio_den
);
  logic [9:0] prod;
  logic [6:0] fnum;

  assign prod = ({1'b0, ctl_word[3:0]} + 5'd1) * ({1'b0, ctl_word[13:10]} + 5'd1);
  assign fnum = {1'b0, ctl_word[9:4]} + 7'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_num <= 7'd1;
      ratio_den <= 10'd1;
    end else if (ctl_word[B_BYP]) begin
      ratio_num <= 7'd1;
      ratio_den <= 10'd1;
    end else if (!ctl_word[B_PWR]) begin
      ratio_num <= 7'd0;
      ratio_den <= 10'd1;
    end else begin
      ratio_num <= fnum;
      ratio_den <= prod;
    end
  end
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
  import pllseq_pkg::*;
#(
  parameter int IDX         = 0,
  parameter int HOLD_CYC    = 4,
  parameter int TIMEOUT_CYC = 1000,
  localparam int LOCK_W     = (IDX == 0) ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic [LOCK_W-1:0] lock_in,
  input  logic [1:0]        src_sel,
  output logic [27:0]       ctl_word,
  output logic              slip_clr,
  output logic              cpu_sel_pll,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [6:0]        ratio_num,
  output logic [9:0]        ratio_den
);
  logic [3:0] fac_r, fac_od;
  logic [5:0] fac_f, fac_bw;
  logic       rst_b, pwr_b, byp_b, en_b;

  pllseq_fsm #(
    .IDX(IDX), .HOLD_CYC(HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .LOCK_W(LOCK_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .lock_in(lock_in),
    .fac_r(fac_r), .fac_f(fac_f), .fac_od(fac_od), .fac_bw(fac_bw),
    .rst_b(rst_b), .pwr_b(pwr_b), .byp_b(byp_b), .en_b(en_b),
    .cpu_sel(cpu_sel_pll), .slip(slip_clr), .busy(busy), .done(done), .err(err)
  );

  pllseq_word #(.IDX(IDX)) word_i (
    .clk(clk), .rst(rst), .src_sel(src_sel),
    .fac_r(fac_r), .fac_f(fac_f), .fac_od(fac_od), .fac_bw(fac_bw),
    .rst_b(rst_b), .pwr_b(pwr_b), .byp_b(byp_b), .en_b(en_b),
    .ctl_word(ctl_word)
  );

  pllseq_ratio ratio_i (
    .clk(clk), .rst(rst), .ctl_word(ctl_word),
    .ratio_num(ratio_num), .ratio_den(ratio_den)
  );
endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk #(
  parameter int IDX = 0
) (
  input logic        clk,
  input logic        rst,
  input logic [27:0] ctl_word,
  input logic        slip_clr,
  input logic        cpu_sel_pll,
  input logic        busy,
  input logic        done,
  input logic        err
);
  // enable rises only with power on, reset low and bypass released
  assert_enable_clean_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_word[25]) |-> (ctl_word[21] && !ctl_word[20] && !ctl_word[23]));

  // reset bit falls only while power is applied
  assert_reset_powered_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_word[20]) |-> ctl_word[21]);

  // CPU selector is on the oscillator when enable rises on instance 0
  assert_cpu_fallback_R4: assert property (@(posedge clk) disable iff (rst)
    ((IDX == 0) && $rose(ctl_word[25])) |-> !cpu_sel_pll);

  // slip strobe only inside a sequence
  assert_slip_busy_R5: assert property (@(posedge clk) disable iff (rst)
    slip_clr |-> busy);

  // timeout leaves the PLL bypassed and disabled
  assert_timeout_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (ctl_word[23] && !ctl_word[25] && done));

  // power drops only after bypass was already set
  assert_bypass_first_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_word[21]) |-> ($past(ctl_word[23]) && ctl_word[23]));
endmodule

bind pllseq_top pllseq_chk #(.IDX(IDX)) chk_i (
  .clk(clk), .rst(rst), .ctl_word(ctl_word), .slip_clr(slip_clr),
  .cpu_sel_pll(cpu_sel_pll), .busy(busy), .done(done), .err(err)
);

// File: tb/pllseq_top_tb_top.sv
`timescale 1ns/1ps
module pllseq_top_tb_top;
  localparam int HOLD = 3;
  localparam int TOUT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_req = 1'b0, dis_req = 1'b0;
  logic [1:0]  lock_in = 2'b00;
  logic [1:0]  src_sel = 2'b10;
  logic [27:0] ctl_word;
  logic        slip_clr, cpu_sel_pll, busy, done, err;
  logic [6:0]  ratio_num;
  logic [9:0]  ratio_den;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  bit finished = 0;
  int stuck_lock = 0;

  always #2 clk = ~clk;

  pllseq_top #(.IDX(0), .HOLD_CYC(HOLD), .TIMEOUT_CYC(TOUT)) dut_i (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .lock_in(lock_in),
    .src_sel(src_sel), .ctl_word(ctl_word), .slip_clr(slip_clr),
    .cpu_sel_pll(cpu_sel_pll), .busy(busy), .done(done), .err(err),
    .ratio_num(ratio_num), .ratio_den(ratio_den)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_r, m_f, m_od, m_bw, m_pos, m_cnt, m_num, m_den;
  bit m_rst, m_pwr, m_byp, m_en, m_cpu, m_slip, m_done, m_err;

  function automatic longint m_word();
    return longint'(m_r) | (longint'(m_f) << 4) | (longint'(m_od) << 10) |
           (longint'(m_bw) << 14) | (longint'(m_rst) << 20) |
           (longint'(m_pwr) << 21) | (longint'(m_byp) << 23) | (longint'(m_en) << 25);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_r = 0; m_f = 0; m_od = 0; m_bw = 0; m_pos = 0; m_cnt = 0;
      m_rst = 0; m_pwr = 0; m_byp = 1; m_en = 0; m_cpu = 1;
      m_slip = 0; m_done = 0; m_err = 0; m_num = 1; m_den = 1;
    end else begin
      if (m_byp)       begin m_num = 1; m_den = 1; end
      else if (!m_pwr) begin m_num = 0; m_den = 1; end
      else begin m_num = m_f + 1; m_den = (m_r + 1) * (m_od + 1); end
      m_done = 0; m_slip = 0;
      if (m_pos == 0) begin
        if (en_req) begin
          m_err = 0;
          if (!m_rst && m_pwr && m_en) m_done = 1; else m_pos = 1;
        end else if (dis_req) begin
          m_err = 0; m_pos = 20;
        end
      end else if (m_pos == 1) begin m_cpu = 0; m_pos = 2; end
      else if (m_pos == 2) begin
        m_r = 0; m_f = 59; m_od = 1; m_bw = 59; m_pwr = 1; m_pos = 3;
      end
      else if (m_pos == 3) begin m_rst = 0; m_pos = 4; end
      else if (m_pos == 4) begin m_rst = 1; m_cnt = 0; m_pos = 5; end
      else if (m_pos == 5) begin
        if (m_cnt == HOLD - 1) m_pos = 6; else m_cnt++;
      end
      else if (m_pos == 6) begin m_rst = 0; m_cnt = 0; m_pos = 7; end
      else if (m_pos == 7) begin
        if (lock_in == 2'b11) m_pos = 8;
        else if (m_cnt == TOUT - 1) begin m_err = 1; m_done = 1; m_pos = 0; end
        else begin m_slip = 1; m_cnt++; end
      end
      else if (m_pos == 8) begin m_byp = 0; m_en = 1; m_pos = 9; end
      else if (m_pos == 9) begin m_cpu = 1; m_done = 1; m_pos = 0; end
      else if (m_pos == 20) begin m_byp = 1; m_pos = 21; end
      else if (m_pos == 21) begin m_pwr = 0; m_en = 0; m_done = 1; m_pos = 0; end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(cur_req, "word",  ctl_word,    m_word());
      check(cur_req, "busy",  busy,        m_pos != 0);
      check(cur_req, "done",  done,        m_done);
      check(cur_req, "err",   err,         m_err);
      check(cur_req, "slip",  slip_clr,    m_slip);
      check(cur_req, "cpu",   cpu_sel_pll, m_cpu);
      check(cur_req, "num",   ratio_num,   m_num);
      check(cur_req, "den",   ratio_den,   m_den);
    end
  end

  // ---------------- lock stub and monitors ----------------
  int lk_cnt = 0;
  int rst_hi = 0, slips = 0;
  bit saw_cpu_low = 0;
  bit prev_pwr = 0, prev_byp = 1, off_ok = 1;
  always @(negedge clk) begin
    if (!ctl_word[21] || ctl_word[20]) lk_cnt = 0; else lk_cnt++;
    if (stuck_lock != 0) lock_in <= (lk_cnt >= 3) ? 2'b01 : 2'b00;
    else lock_in <= (lk_cnt >= 5) ? 2'b11 : ((lk_cnt >= 3) ? 2'b01 : 2'b00);
    if (ctl_word[20]) rst_hi++;
    if (slip_clr) slips++;
    if (!cpu_sel_pll) saw_cpu_low = 1;
    if (prev_pwr && !ctl_word[21] && !prev_byp) off_ok = 0;
    prev_pwr = ctl_word[21];
    prev_byp = ctl_word[23];
  end

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "ctl", ctl_word, 28'h0800000);
    check("R1", "busy", busy, 0);
    check("R1", "err", err, 0);
    check("R1", "done", done, 0);
    check("R1", "cpu", cpu_sel_pll, 1);
    check("R1", "ratio", {ratio_num, ratio_den}, {7'd1, 10'd1});

    // R3/R4/R5/R9 power-up with late lock and stray requests while busy
    cur_req = "R3"; rst_hi = 0; slips = 0; saw_cpu_low = 0;
    @(negedge clk) en_req = 1;
    @(negedge clk) en_req = 0;
    repeat (3) @(negedge clk);
    cur_req = "R9";
    dis_req = 1; en_req = 1;
    @(negedge clk) dis_req = 0; en_req = 0;
    check("R9", "busy after stray", busy, 1);
    wait_idle();
    check("R2", "ctl", ctl_word,
          (28'd1 << 25) | (28'd1 << 21) | (28'd59 << 14) | (28'd1 << 10) | (28'd59 << 4));
    check("R3", "reset high cycles", rst_hi, HOLD + 1);
    check("R4", "cpu fallback seen", saw_cpu_low, 1);
    check("R4", "cpu restored", cpu_sel_pll, 1);
    check("R5", "slip pulses", slips > 0, 1);
    check("R12", "sel bits", ctl_word[27:26], 0);
    @(negedge clk);
    check("R11", "ratio", {ratio_num, ratio_den}, {7'd60, 10'd2});

    // R7 already enabled
    cur_req = "R7";
    en_req = 1;
    @(negedge clk) en_req = 0;
    check("R7", "done", done, 1);
    check("R7", "busy", busy, 0);

    // R8 power-down
    cur_req = "R8"; off_ok = 1;
    dis_req = 1;
    @(negedge clk) dis_req = 0;
    wait_idle();
    check("R8", "bypass before power off", off_ok, 1);
    check("R8", "ctl bits", ctl_word[25:20], 6'b001000);
    @(negedge clk);
    check("R11", "bypass ratio", {ratio_num, ratio_den}, {7'd1, 10'd1});

    // R10 simultaneous requests
    cur_req = "R10";
    en_req = 1; dis_req = 1;
    @(negedge clk) en_req = 0; dis_req = 0;
    wait_idle();
    check("R10", "enable wins", ctl_word[25], 1);

    // R6 timeout with partial lock
    cur_req = "R8";
    dis_req = 1;
    @(negedge clk) dis_req = 0;
    wait_idle();
    cur_req = "R6"; stuck_lock = 1;
    en_req = 1;
    @(negedge clk) en_req = 0;
    wait_idle();
    check("R6", "err", err, 1);
    check("R6", "bypass kept", ctl_word[23], 1);
    check("R6", "enable off", ctl_word[25], 0);
    check("R5", "partial lock rejected", ctl_word[25], 0);
    stuck_lock = 0;
    repeat (2) @(negedge clk);
    en_req = 1;
    @(negedge clk) en_req = 0;
    check("R6", "err cleared", err, 0);
    wait_idle();
    check("R6", "recovered", ctl_word[25], 1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule